// File: doc/BRIEF.md
# FIFO Threshold Crossing Interrupt Logic

This block sits beside a pair of 64-byte byte FIFOs that connect a USB serial engine to a CPU bus. It watches the receive FIFO as it fills and the transmit FIFO as it drains. When a byte moves while a FIFO's fill level equals its programmed threshold, the block records a sticky status flag. The receive flag marks "almost full" and the transmit flag marks "almost empty".

Each flag has its own enable bit. When a flag and its enable bit are both set, the block asserts a single local interrupt. Software reads the flags through a small register port and clears each flag by writing 1 to its bit.

A flag is set by the event of a byte moving at the threshold, not by comparing the level with the threshold. A flag is therefore raised once per crossing and does not follow the level. The FIFO storage, the protocol engine and the chip-level interrupt controller are outside this block.

Top module: `fifo_thresh_irq`

## Requirements
- R1: After reset the enable register and the status register both read 0, and `irq` is low.
- R2: A cycle with `rx_push` high and `rx_count` equal to `rx_thresh` sets status bit 0, which is readable after that clock edge. A push at any other count does not set the bit, and neither does a count match without a push.
- R3: A cycle with `tx_pop` high and `tx_count` equal to `tx_thresh` sets status bit 1, which is readable after that clock edge. A pop at any other count does not set the bit, and neither does a count match without a pop.
- R4: A push while `rx_count` is 64 (the FIFO is full) never sets bit 0, so a receive threshold of 64 never fires. A pop while `tx_count` is 0 never sets bit 1, so a transmit threshold of 0 never fires.
- R5: A set status bit stays set over any number of cycles until software clears it.
- R6: A write to the status register (`reg_addr`=1) clears each bit whose `reg_wdata` bit is 1. A 0 in `reg_wdata` leaves the matching bit unchanged.
- R7: If a set event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R8: `reg_addr`=0 selects the enable register and `reg_addr`=1 selects the status register. In both registers bit 0 is receive and bit 1 is transmit. Bits 31..2 read as 0 whatever is written to them. A write to the enable register stores `reg_wdata[1:0]`.
- R9: `irq` is registered and equals, one cycle later, the OR over both bits of (status AND enable). It rises one clock after a flag and its enable bit are both set, and it falls one clock after that condition ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_push | input | 1 | A byte is written from the USB side into the receive FIFO this cycle |
| rx_count | input | 7 | Current receive FIFO fill level, 0..64 |
| rx_thresh | input | 7 | Receive almost-full threshold |
| tx_pop | input | 1 | A byte is read from the transmit FIFO toward the USB side this cycle |
| tx_count | input | 7 | Current transmit FIFO fill level, 0..64 |
| tx_thresh | input | 7 | Transmit almost-empty threshold |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 enable, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read of the selected register |
| irq | output | 1 | Local interrupt request |

## Verification
A wrong internal state of this block shows at the ports within one clock. A flag that is lost, stuck or set by mistake appears on the status readback at the first read after the edge where it went wrong. A wrong enable value or a stale interrupt term shows on `irq` one further edge later. The bench therefore reads the status register right after each byte event and write, and it samples `irq` on exactly the second edge. This covers the boundary cases at the full and empty counts and the cycle in which a set and a clear collide.

// File: rtl/fti_pkg.sv
package fti_pkg;

    localparam int unsigned NUM_SRC = 2;
    localparam int unsigned SRC_RX  = 0;
    localparam int unsigned SRC_TX  = 1;

    localparam logic ADDR_ENABLE = 1'b0;
    localparam logic ADDR_STATUS = 1'b1;

    typedef enum logic {
        DIR_FILL  = 1'b0,
        DIR_DRAIN = 1'b1
    } fill_dir_e;

    typedef struct packed {
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] status;
        logic               irq;
    } ctl_state_t;

endpackage

// File: rtl/fti_cross.sv
module fti_cross
    import fti_pkg::*;
#(
    parameter int        DEPTH = 64,
    parameter int        CNT_W = $clog2(DEPTH + 1),
    parameter fill_dir_e DIR   = DIR_FILL
) (
    input  logic             strobe_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [CNT_W-1:0] thresh_i,
    output logic             hit_o
);

    localparam logic [CNT_W-1:0] FULL_LEVEL = CNT_W'(DEPTH);

    logic movable;

    generate
        if (DIR == DIR_FILL) begin : g_fill
            always_comb movable = (count_i < FULL_LEVEL);
        end else begin : g_drain
            always_comb movable = (count_i != '0);
        end
    endgenerate

    always_comb begin
        hit_o = strobe_i && movable && (count_i == thresh_i);
    end

endmodule

// File: rtl/fti_regs.sv
module fti_regs
    import fti_pkg::*;
#(
    parameter int NSRC   = NUM_SRC,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   set_i,
    input  logic              wr_i,
    input  logic              addr_i,
    input  logic [NSRC-1:0]   wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [NSRC-1:0] enable_d, enable_q;
    logic [NSRC-1:0] status_d, status_q;
    logic            irq_d, irq_q;
    logic [NSRC-1:0] clr_mask;

    always_comb begin
        enable_d = enable_q;
        clr_mask = '0;
        if (wr_i && addr_i == ADDR_ENABLE) begin
            enable_d = wdata_i;
        end
        if (wr_i && addr_i == ADDR_STATUS) begin
            clr_mask = wdata_i;
        end
        status_d = (status_q & ~clr_mask) | set_i;
        irq_d    = |(status_q & enable_q);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            status_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            enable_q <= enable_d;
            status_q <= status_d;
            irq_q    <= irq_d;
        end
    end

    always_comb begin
        rdata_o = '0;
        rdata_o[NSRC-1:0] = (addr_i == ADDR_STATUS) ? status_q : enable_q;
    end

    assign irq_o = irq_q;

    // R2 R3 R7
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

    // R2 R3
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0) |=> ((status_q & ~$past(status_q)) == '0));

    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == ADDR_STATUS) |=> ((status_q & $past(status_q)) == $past(status_q)));

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == ADDR_STATUS) |=> ((status_q & $past(wdata_i & ~set_i)) == '0));

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) != '0) |=> irq_o);

    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((status_q & enable_q) == '0) |=> !irq_o);

endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
    import fti_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic [CNT_W-1:0]  rx_count,
    input  logic [CNT_W-1:0]  rx_thresh,
    input  logic              tx_pop,
    input  logic [CNT_W-1:0]  tx_count,
    input  logic [CNT_W-1:0]  tx_thresh,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    logic [NUM_SRC-1:0] strobe;
    logic [CNT_W-1:0]   level  [NUM_SRC];
    logic [CNT_W-1:0]   thresh [NUM_SRC];
    logic [NUM_SRC-1:0] hit;
    logic               unused_wdata_hi;

    assign strobe[SRC_RX] = rx_push;
    assign strobe[SRC_TX] = tx_pop;
    assign level[SRC_RX]  = rx_count;
    assign level[SRC_TX]  = tx_count;
    assign thresh[SRC_RX] = rx_thresh;
    assign thresh[SRC_TX] = tx_thresh;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:NUM_SRC];

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            fti_cross #(
                .DEPTH (DEPTH),
                .CNT_W (CNT_W),
                .DIR   ((s == SRC_RX) ? DIR_FILL : DIR_DRAIN)
            ) u_cross (
                .strobe_i (strobe[s]),
                .count_i  (level[s]),
                .thresh_i (thresh[s]),
                .hit_o    (hit[s])
            );
        end
    endgenerate

    fti_regs #(
        .NSRC   (NUM_SRC),
        .DATA_W (DATA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_i   (hit),
        .wr_i    (reg_wr),
        .addr_i  (reg_addr),
        .wdata_i (reg_wdata[NUM_SRC-1:0]),
        .rdata_o (reg_rdata),
        .irq_o   (irq)
    );

    // R4
    full_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_count == CNT_W'(DEPTH) && reg_rdata[SRC_RX] == 1'b0 && reg_addr == ADDR_STATUS)
        |=> (reg_rdata[SRC_RX] == 1'b0 || reg_addr != ADDR_STATUS));

endmodule

// File: tb/fifo_thresh_irq_test.sv
`timescale 1ns/1ps
module fifo_thresh_irq_test;

    localparam int CNT_W = 7;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             rx_push, tx_pop, reg_wr, reg_addr;
    logic [CNT_W-1:0] rx_count, rx_thresh, tx_count, tx_thresh;
    logic [31:0]      reg_wdata, reg_rdata;
    logic             irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fifo_thresh_irq uut (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_count(rx_count), .rx_thresh(rx_thresh),
        .tx_pop(tx_pop), .tx_count(tx_count), .tx_thresh(tx_thresh),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic reg_write(logic addr, logic [31:0] data);
        reg_addr = addr; reg_wdata = data; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic read_reg(logic addr, output logic [31:0] data);
        reg_addr = addr;
        #1;
        data = reg_rdata;
    endtask

    task automatic rx_event(logic [CNT_W-1:0] cnt);
        rx_count = cnt; rx_push = 1'b1;
        tick();
        rx_push = 1'b0;
    endtask

    task automatic tx_event(logic [CNT_W-1:0] cnt);
        tx_count = cnt; tx_pop = 1'b1;
        tick();
        tx_pop = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        read_reg(1'b0, d); check("R1 enable after reset", d, 0);
        read_reg(1'b1, d); check("R1 status after reset", d, 0);
        check("R1 irq after reset", irq, 0);
    endtask

    task automatic t_rx_set();
        logic [31:0] d;
        rx_thresh = 20;
        rx_event(19);
        read_reg(1'b1, d); check("R2 push below threshold", d, 0);
        rx_event(21);
        read_reg(1'b1, d); check("R2 push above threshold", d, 0);
        rx_event(20);
        read_reg(1'b1, d); check("R2 push at threshold", d, 32'h1);
    endtask

    task automatic t_tx_set();
        logic [31:0] d;
        tx_thresh = 5;
        tx_event(6);
        read_reg(1'b1, d); check("R3 pop off threshold", d, 32'h1);
        tx_event(5);
        read_reg(1'b1, d); check("R3 pop at threshold", d, 32'h3);
    endtask

    task automatic t_sticky();
        logic [31:0] d;
        rx_count = 3; tx_count = 40;
        for (int i = 0; i < 5; i++) tick();
        read_reg(1'b1, d); check("R5 flags held", d, 32'h3);
    endtask

    task automatic t_clear();
        logic [31:0] d;
        reg_write(1'b1, 32'h0);
        read_reg(1'b1, d); check("R6 write zero no effect", d, 32'h3);
        reg_write(1'b1, 32'h1);
        read_reg(1'b1, d); check("R6 clear bit0 only", d, 32'h2);
        reg_write(1'b1, 32'h2);
        read_reg(1'b1, d); check("R6 clear bit1", d, 32'h0);
        rx_count = rx_thresh; tx_count = tx_thresh;
        tick(); tick();
        read_reg(1'b1, d); check("R2 R3 count match without strobe", d, 32'h0);
    endtask

    task automatic t_bounds();
        logic [31:0] d;
        rx_thresh = 64;
        rx_event(64);
        read_reg(1'b1, d); check("R4 push at full with threshold 64", d, 32'h0);
        tx_thresh = 0;
        tx_event(0);
        read_reg(1'b1, d); check("R4 pop at empty with threshold 0", d, 32'h0);
        rx_thresh = 63;
        rx_event(63);
        read_reg(1'b1, d); check("R2 push at 63 with threshold 63", d, 32'h1);
        reg_write(1'b1, 32'h1);
    endtask

    task automatic t_race();
        logic [31:0] d;
        rx_thresh = 8; rx_count = 8; rx_push = 1'b1;
        reg_addr = 1'b1; reg_wdata = 32'h1; reg_wr = 1'b1;
        tick();
        rx_push = 1'b0; reg_wr = 1'b0; reg_wdata = '0;
        read_reg(1'b1, d); check("R7 set beats clear", d, 32'h1);
        reg_write(1'b1, 32'h1);
        read_reg(1'b1, d); check("R7 later clear works", d, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        reg_write(1'b0, 32'hFFFF_FFFE);
        read_reg(1'b0, d); check("R8 enable stores low bits only", d, 32'h2);
        read_reg(1'b1, d); check("R8 status unaffected by enable write", d, 32'h0);
        tx_thresh = 10;
        tx_event(10);
        read_reg(1'b1, d); check("R8 tx flag in bit 1", d, 32'h2);
        reg_write(1'b1, 32'hFFFF_FFFF);
        read_reg(1'b1, d); check("R8 all-ones write clears", d, 32'h0);
        reg_write(1'b0, 32'h0);
        tick();
    endtask

    task automatic t_irq();
        logic [31:0] d;
        reg_write(1'b0, 32'h1);
        tick();
        check("R9 irq low with no flags", irq, 0);
        tx_thresh = 12;
        tx_event(12);
        tick(); tick();
        check("R9 disabled tx flag gives no irq", irq, 0);
        rx_thresh = 30;
        rx_event(30);
        check("R9 irq latency one cycle (not yet)", irq, 0);
        tick();
        check("R9 irq raised", irq, 1);
        reg_write(1'b0, 32'h0);
        check("R9 irq one cycle after disable", irq, 1);
        tick();
        check("R9 irq falls after disable", irq, 0);
        reg_write(1'b0, 32'h2);
        tick();
        check("R9 tx enable raises irq", irq, 1);
        reg_write(1'b1, 32'h3);
        tick();
        check("R9 irq falls after clear", irq, 0);
        read_reg(1'b1, d); check("R9 status cleared", d, 0);
        reg_write(1'b0, 32'h0);
    endtask

    initial begin
        rst_n = 1'b0;
        rx_push = 0; tx_pop = 0; reg_wr = 0; reg_addr = 0; reg_wdata = '0;
        rx_count = 0; tx_count = 0; rx_thresh = 0; tx_thresh = 0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_rx_set();
        t_tx_set();
        t_sticky();
        t_clear();
        t_bounds();
        t_race();
        t_layout();
        t_irq();
        done = 1;
    end

    initial begin
        for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule